// File: doc/BRIEF.md
# Page Translation Cache with Global Entries

This block keeps recently used virtual-to-physical page translations so that most memory accesses skip the table walk. It has two fully associative sets. One set holds 4 kB translations and is tagged by virtual address bits [31:12]. The other holds 4 MB translations and is tagged by virtual address bits [31:22]. The lookup runs combinationally on the stored entries, and its result is registered. One cycle after a request, the block returns either a physical address with the permission bits, or a request for the page walker to fetch the translation.

The walker writes a translation back through the fill port. A fill whose tag is already resident overwrites that entry in place. Any other fill replaces the entry at the set's round-robin pointer. When the directory base changes, software pulses the flush input. The flush removes every entry whose global flag is clear. Software can also remove one page from both sets when a table in memory changes.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry is invalid, `rsp_valid_o` is 0, and the first lookup reports a walk.
- R2: The response for a lookup appears in the cycle after `lookup_valid_i`. `rsp_valid_o`, `rsp_hit_o` and `rsp_walk_o` are 0 in a cycle that follows no lookup. A 4 kB hit returns {stored frame[19:0], vaddr[11:0]}.
- R3: A lookup that matches no valid entry returns `rsp_walk_o`=1, `rsp_hit_o`=0 and `rsp_paddr_o`=0.
- R4: A 4 MB fill (`fill_big_i`=1) stores tag `fill_vpn_i[19:10]` and frame `fill_pfn_i[19:10]`. A hit in that set returns {frame[9:0], vaddr[21:0]} and `rsp_big_o`=1.
- R5: When both sets hit, the 4 MB translation is returned.
- R6: A write lookup that hits an entry whose dirty bit is 0 reports a walk and no hit. A read of the same entry hits. A write to an entry whose dirty bit is 1 hits.
- R7: A `flush_i` pulse invalidates every entry whose global bit is 0 and keeps every entry whose global bit is 1.
- R8: `inval_i` with `inval_vpn_i` removes the matching 4 kB entry and any 4 MB entry tagged `inval_vpn_i[19:10]`, global or not. Entries that do not match stay valid.
- R9: A fill of a non-resident tag replaces entries in round-robin order starting at entry 0. After 32 distinct 4 kB fills from reset, the 33rd evicts the first one filled and keeps the second.
- R10: A fill of a tag already resident in its set updates that entry in place and does not advance the pointer. A tag is never held twice.
- R11: A fill presented in the same cycle as `flush_i` or `inval_i` is dropped.
- R12: A hit returns the stored user/supervisor, read/write and dirty bits on `rsp_us_o`, `rsp_rw_o` and `rsp_dirty_o`. Fill attribute order is {us, rw, dirty, global}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lookup_valid_i | input | 1 | Lookup request |
| lookup_vaddr_i | input | 32 | Virtual address to translate |
| lookup_write_i | input | 1 | Lookup is for a write |
| fill_valid_i | input | 1 | Write one translation |
| fill_big_i | input | 1 | 1 selects the 4 MB set |
| fill_vpn_i | input | 20 | Virtual page number, vaddr[31:12] |
| fill_pfn_i | input | 20 | Physical frame number |
| fill_attr_i | input | 4 | {us, rw, dirty, global} |
| flush_i | input | 1 | Directory base change: drop non-global entries |
| inval_i | input | 1 | Single-page invalidate |
| inval_vpn_i | input | 20 | Page to invalidate, vaddr[31:12] |
| rsp_valid_o | output | 1 | Lookup result valid |
| rsp_hit_o | output | 1 | Translation found |
| rsp_walk_o | output | 1 | Walk request |
| rsp_paddr_o | output | 32 | Physical address on a hit, else 0 |
| rsp_us_o | output | 1 | User-accessible bit of the hit entry |
| rsp_rw_o | output | 1 | Writable bit of the hit entry |
| rsp_dirty_o | output | 1 | Dirty bit of the hit entry |
| rsp_big_o | output | 1 | Hit came from the 4 MB set |

## Verification
The hardest state to reach from the ports is a full 4 kB set with its round-robin pointer wrapped back to entry 0. It takes 32 distinct fills to get there, and at that point a refill of a resident tag must not disturb the pointer. The bench fills 32 pages, refills one of them with a new frame, and then adds a 33rd page. It expects only the first-filled page to be lost, and expects the refilled page to return its new frame. Cases where both sets hit, and a fill arriving in the same cycle as a flush, are set up directly with back-to-back fills, so that priority and drop rules are seen at the response port.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef struct packed {
    logic us;
    logic rw;
    logic dirty;
    logic glob;
  } xlat_attr_t;
endpackage

// File: rtl/xlat_set.sv
module xlat_set
  import xlat_pkg::*;
#(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned TAG_W   = 20,
  parameter int unsigned PFN_W   = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TAG_W-1:0] look_tag_i,
  output logic             hit_o,
  output logic [PFN_W-1:0] pfn_o,
  output xlat_attr_t       attr_o,
  input  logic             fill_en_i,
  input  logic [TAG_W-1:0] fill_tag_i,
  input  logic [PFN_W-1:0] fill_pfn_i,
  input  xlat_attr_t       fill_attr_i,
  input  logic             flush_i,
  input  logic             inval_i,
  input  logic [TAG_W-1:0] inval_tag_i
);
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic             valid_q [ENTRIES];
  logic [TAG_W-1:0] tag_q   [ENTRIES];
  logic [PFN_W-1:0] pfn_q   [ENTRIES];
  xlat_attr_t       attr_q  [ENTRIES];

  logic [ENTRIES-1:0] look_match, fill_match, inval_match, valid_vec, glob_vec;
  logic [IDX_W-1:0]   ptr_q, fill_idx;
  logic               fill_hit, do_fill;

  assign do_fill = fill_en_i && !flush_i && !inval_i;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign look_match[g]  = valid_q[g] && (tag_q[g] == look_tag_i);
    assign fill_match[g]  = valid_q[g] && (tag_q[g] == fill_tag_i);
    assign inval_match[g] = valid_q[g] && (tag_q[g] == inval_tag_i);
    assign valid_vec[g]   = valid_q[g];
    assign glob_vec[g]    = attr_q[g].glob;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[g] <= 1'b0;
      end else if (flush_i || inval_i) begin
        if (flush_i && !attr_q[g].glob) valid_q[g] <= 1'b0;
        if (inval_i && inval_match[g])  valid_q[g] <= 1'b0;
      end else if (do_fill && fill_idx == IDX_W'(g)) begin
        valid_q[g] <= 1'b1;
      end
    end

    always_ff @(posedge clk_i) begin
      if (do_fill && fill_idx == IDX_W'(g)) begin
        tag_q[g]  <= fill_tag_i;
        pfn_q[g]  <= fill_pfn_i;
        attr_q[g] <= fill_attr_i;
      end
    end
  end

  always_comb begin
    hit_o  = |look_match;
    pfn_o  = '0;
    attr_o = '0;
    for (int i = int'(ENTRIES) - 1; i >= 0; i--) begin
      if (look_match[i]) begin
        pfn_o  = pfn_q[i];
        attr_o = attr_q[i];
      end
    end
  end

  // resident tag is overwritten in place, otherwise the pointer slot
  always_comb begin
    fill_hit = |fill_match;
    fill_idx = ptr_q;
    for (int i = int'(ENTRIES) - 1; i >= 0; i--) begin
      if (fill_match[i]) fill_idx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (do_fill && !fill_hit) begin
      ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  AST_NO_DUP_TAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(look_match)); // R10
  AST_FLUSH_KEEPS_GLOBAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> ((valid_vec & ~glob_vec) == '0)); // R7
  AST_FILL_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_fill |=> (valid_vec != '0)); // R9
endmodule

// File: rtl/xlat_pick.sv
module xlat_pick
  import xlat_pkg::*;
#(
  parameter int unsigned VA_W     = 32,
  parameter int unsigned SM_OFF_W = 12,
  parameter int unsigned BG_OFF_W = 22,
  localparam int unsigned SM_PFN_W = VA_W - SM_OFF_W,
  localparam int unsigned BG_PFN_W = VA_W - BG_OFF_W
) (
  input  logic                sm_hit_i,
  input  logic [SM_PFN_W-1:0] sm_pfn_i,
  input  xlat_attr_t          sm_attr_i,
  input  logic                bg_hit_i,
  input  logic [BG_PFN_W-1:0] bg_pfn_i,
  input  xlat_attr_t          bg_attr_i,
  input  logic [BG_OFF_W-1:0] va_off_i,
  input  logic                write_i,
  output logic                hit_o,
  output logic                walk_o,
  output logic [VA_W-1:0]     paddr_o,
  output xlat_attr_t          attr_o,
  output logic                big_o
);
  xlat_attr_t sel_attr;
  logic       any_hit, blocked;

  always_comb begin
    any_hit  = sm_hit_i || bg_hit_i;
    sel_attr = bg_hit_i ? bg_attr_i : sm_attr_i;
    // write to a clean page goes to the walker so it can mark it dirty
    blocked  = write_i && !sel_attr.dirty;
    hit_o    = any_hit && !blocked;
    walk_o   = !hit_o;
    big_o    = hit_o && bg_hit_i;
    attr_o   = hit_o ? sel_attr : '0;
    if (!hit_o)        paddr_o = '0;
    else if (bg_hit_i) paddr_o = {bg_pfn_i, va_off_i};
    else               paddr_o = {sm_pfn_i, va_off_i[SM_OFF_W-1:0]};
  end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int unsigned VA_W       = 32,
  parameter int unsigned SM_OFF_W   = 12,
  parameter int unsigned BG_OFF_W   = 22,
  parameter int unsigned SM_ENTRIES = 32,
  parameter int unsigned BG_ENTRIES = 4,
  localparam int unsigned SM_PFN_W  = VA_W - SM_OFF_W,
  localparam int unsigned BG_PFN_W  = VA_W - BG_OFF_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                lookup_valid_i,
  input  logic [VA_W-1:0]     lookup_vaddr_i,
  input  logic                lookup_write_i,
  input  logic                fill_valid_i,
  input  logic                fill_big_i,
  input  logic [SM_PFN_W-1:0] fill_vpn_i,
  input  logic [SM_PFN_W-1:0] fill_pfn_i,
  input  logic [3:0]          fill_attr_i,
  input  logic                flush_i,
  input  logic                inval_i,
  input  logic [SM_PFN_W-1:0] inval_vpn_i,
  output logic                rsp_valid_o,
  output logic                rsp_hit_o,
  output logic                rsp_walk_o,
  output logic [VA_W-1:0]     rsp_paddr_o,
  output logic                rsp_us_o,
  output logic                rsp_rw_o,
  output logic                rsp_dirty_o,
  output logic                rsp_big_o
);
  logic                sm_hit, bg_hit;
  logic [SM_PFN_W-1:0] sm_pfn;
  logic [BG_PFN_W-1:0] bg_pfn;
  xlat_attr_t          sm_attr, bg_attr, pick_attr, fill_attr;
  logic                pick_hit, pick_walk, pick_big;
  logic [VA_W-1:0]     pick_paddr;
  logic                wr_q;

  assign fill_attr = xlat_attr_t'(fill_attr_i);

  xlat_set #(.ENTRIES(SM_ENTRIES), .TAG_W(SM_PFN_W), .PFN_W(SM_PFN_W)) u_small (
    .clk_i, .rst_ni,
    .look_tag_i  (lookup_vaddr_i[VA_W-1:SM_OFF_W]),
    .hit_o       (sm_hit),
    .pfn_o       (sm_pfn),
    .attr_o      (sm_attr),
    .fill_en_i   (fill_valid_i && !fill_big_i),
    .fill_tag_i  (fill_vpn_i),
    .fill_pfn_i  (fill_pfn_i),
    .fill_attr_i (fill_attr),
    .flush_i,
    .inval_i,
    .inval_tag_i (inval_vpn_i)
  );

  xlat_set #(.ENTRIES(BG_ENTRIES), .TAG_W(BG_PFN_W), .PFN_W(BG_PFN_W)) u_big (
    .clk_i, .rst_ni,
    .look_tag_i  (lookup_vaddr_i[VA_W-1:BG_OFF_W]),
    .hit_o       (bg_hit),
    .pfn_o       (bg_pfn),
    .attr_o      (bg_attr),
    .fill_en_i   (fill_valid_i && fill_big_i),
    .fill_tag_i  (fill_vpn_i[SM_PFN_W-1 -: BG_PFN_W]),
    .fill_pfn_i  (fill_pfn_i[SM_PFN_W-1 -: BG_PFN_W]),
    .fill_attr_i (fill_attr),
    .flush_i,
    .inval_i,
    .inval_tag_i (inval_vpn_i[SM_PFN_W-1 -: BG_PFN_W])
  );

  xlat_pick #(.VA_W(VA_W), .SM_OFF_W(SM_OFF_W), .BG_OFF_W(BG_OFF_W)) u_pick (
    .sm_hit_i  (sm_hit),
    .sm_pfn_i  (sm_pfn),
    .sm_attr_i (sm_attr),
    .bg_hit_i  (bg_hit),
    .bg_pfn_i  (bg_pfn),
    .bg_attr_i (bg_attr),
    .va_off_i  (lookup_vaddr_i[BG_OFF_W-1:0]),
    .write_i   (lookup_write_i),
    .hit_o     (pick_hit),
    .walk_o    (pick_walk),
    .paddr_o   (pick_paddr),
    .attr_o    (pick_attr),
    .big_o     (pick_big)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_walk_o  <= 1'b0;
      rsp_paddr_o <= '0;
      rsp_us_o    <= 1'b0;
      rsp_rw_o    <= 1'b0;
      rsp_dirty_o <= 1'b0;
      rsp_big_o   <= 1'b0;
      wr_q        <= 1'b0;
    end else begin
      rsp_valid_o <= lookup_valid_i;
      rsp_hit_o   <= lookup_valid_i && pick_hit;
      rsp_walk_o  <= lookup_valid_i && pick_walk;
      rsp_paddr_o <= lookup_valid_i ? pick_paddr : '0;
      rsp_us_o    <= lookup_valid_i && pick_attr.us;
      rsp_rw_o    <= lookup_valid_i && pick_attr.rw;
      rsp_dirty_o <= lookup_valid_i && pick_attr.dirty;
      rsp_big_o   <= lookup_valid_i && pick_big;
      wr_q        <= lookup_valid_i && lookup_write_i;
    end
  end

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_valid_i |=> rsp_valid_o); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lookup_valid_i |=> (!rsp_valid_o && !rsp_hit_o && !rsp_walk_o)); // R2
  AST_HIT_XOR_WALK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_hit_o ^ rsp_walk_o)); // R3
  AST_WRITE_NEEDS_DIRTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_hit_o && wr_q) |-> rsp_dirty_o); // R6
endmodule

// File: tb/xlat_cache_tb.sv
module xlat_cache_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lookup_valid_i = 1'b0, lookup_write_i = 1'b0;
  logic [31:0] lookup_vaddr_i = '0;
  logic        fill_valid_i = 1'b0, fill_big_i = 1'b0;
  logic [19:0] fill_vpn_i = '0, fill_pfn_i = '0, inval_vpn_i = '0;
  logic [3:0]  fill_attr_i = '0;
  logic        flush_i = 1'b0, inval_i = 1'b0;
  logic        rsp_valid_o, rsp_hit_o, rsp_walk_o, rsp_us_o, rsp_rw_o, rsp_dirty_o, rsp_big_o;
  logic [31:0] rsp_paddr_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  xlat_cache u_dut (
    .clk_i(clk), .rst_ni,
    .lookup_valid_i, .lookup_vaddr_i, .lookup_write_i,
    .fill_valid_i, .fill_big_i, .fill_vpn_i, .fill_pfn_i, .fill_attr_i,
    .flush_i, .inval_i, .inval_vpn_i,
    .rsp_valid_o, .rsp_hit_o, .rsp_walk_o, .rsp_paddr_o,
    .rsp_us_o, .rsp_rw_o, .rsp_dirty_o, .rsp_big_o
  );

  // op: 0 fill 4 kB, 1 fill 4 MB, 2 lookup; attr {us,rw,dirty,global}
  typedef struct packed {
    logic [1:0]  op;
    logic        wr;
    logic [31:0] va;
    logic [19:0] pfn;
    logic [3:0]  attr;
    logic        eh;
    logic        ew;
    logic [31:0] epa;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'd2, 1'b0, 32'h0040_0123, 20'h0,     4'b0000, 1'b0, 1'b1, 32'h0},          // R1 R3
    '{2'd0, 1'b0, 32'h0040_0000, 20'h12345, 4'b1100, 1'b0, 1'b0, 32'h0},
    '{2'd2, 1'b0, 32'h0040_0123, 20'h0,     4'b0000, 1'b1, 1'b0, 32'h1234_5123},  // R2
    '{2'd2, 1'b1, 32'h0040_0123, 20'h0,     4'b0000, 1'b0, 1'b1, 32'h0},          // R6 clean write
    '{2'd0, 1'b0, 32'h0040_0000, 20'h12345, 4'b1110, 1'b0, 1'b0, 32'h0},
    '{2'd2, 1'b1, 32'h0040_0123, 20'h0,     4'b0000, 1'b1, 1'b0, 32'h1234_5123},  // R6 dirty write
    '{2'd1, 1'b0, 32'h0040_0000, 20'hABC00, 4'b0011, 1'b0, 1'b0, 32'h0},
    '{2'd2, 1'b0, 32'h0040_0123, 20'h0,     4'b0000, 1'b1, 1'b0, 32'hABC0_0123},  // R5
    '{2'd2, 1'b0, 32'h007F_FFFC, 20'h0,     4'b0000, 1'b1, 1'b0, 32'hABFF_FFFC},  // R4
    '{2'd2, 1'b0, 32'h0080_0000, 20'h0,     4'b0000, 1'b0, 1'b1, 32'h0}           // R3
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic fill(input logic big, input logic [31:0] va, input logic [19:0] pfn,
                      input logic [3:0] attr);
    fill_valid_i = 1'b1; fill_big_i = big; fill_vpn_i = va[31:12];
    fill_pfn_i = pfn; fill_attr_i = attr;
    @(negedge clk);
    fill_valid_i = 1'b0;
  endtask

  task automatic look(input logic [31:0] va, input logic wr);
    lookup_valid_i = 1'b1; lookup_vaddr_i = va; lookup_write_i = wr;
    @(negedge clk);
    lookup_valid_i = 1'b0; lookup_write_i = 1'b0;
  endtask

  initial begin
    do_reset();
    chk("R1 valid after reset", {31'b0, rsp_valid_o}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].op == 2'd2) begin
        look(VECS[i].va, VECS[i].wr);
        chk($sformatf("R2 vec%0d valid", i), {31'b0, rsp_valid_o}, 32'd1);
        chk($sformatf("R3 vec%0d hit", i),   {31'b0, rsp_hit_o},   {31'b0, VECS[i].eh});
        chk($sformatf("R3 vec%0d walk", i),  {31'b0, rsp_walk_o},  {31'b0, VECS[i].ew});
        chk($sformatf("R4 vec%0d paddr", i), rsp_paddr_o, VECS[i].epa);
      end else begin
        fill(VECS[i].op[0], VECS[i].va, VECS[i].pfn, VECS[i].attr);
      end
    end
    look(32'h0040_0123, 1'b0);
    chk("R4 big flag", {31'b0, rsp_big_o}, 32'd1);
    @(negedge clk);
    chk("R2 idle valid", {29'b0, rsp_valid_o, rsp_hit_o, rsp_walk_o}, 32'd0);

    // R12 permission bits
    fill(1'b0, 32'h0AAA_A000, 20'h0BEEF, 4'b1000);
    look(32'h0AAA_A010, 1'b0);
    chk("R12 us/rw/dirty", {29'b0, rsp_us_o, rsp_rw_o, rsp_dirty_o}, 32'b100);
    chk("R12 paddr", rsp_paddr_o, 32'h0BEE_F010);

    // R7 flush keeps global entries only
    fill(1'b0, 32'h1111_1000, 20'h22222, 4'b0001);
    fill(1'b0, 32'h3333_3000, 20'h44444, 4'b0110);
    flush_i = 1'b1; @(negedge clk); flush_i = 1'b0;
    look(32'h1111_1004, 1'b0);
    chk("R7 global survives", rsp_paddr_o, 32'h2222_2004);
    look(32'h3333_3004, 1'b0);
    chk("R7 non-global dropped", {31'b0, rsp_walk_o}, 32'd1);
    look(32'h0040_0123, 1'b0);
    chk("R7 global 4MB survives", rsp_paddr_o, 32'hABC0_0123);

    // R8 single-page invalidate hits both sets, spares others
    inval_vpn_i = 20'h00400; inval_i = 1'b1; @(negedge clk); inval_i = 1'b0;
    look(32'h0040_0123, 1'b0);
    chk("R8 both sets removed", {31'b0, rsp_walk_o}, 32'd1);
    look(32'h1111_1004, 1'b0);
    chk("R8 other page kept", rsp_paddr_o, 32'h2222_2004);

    // R11 fill concurrent with flush or invalidate is dropped
    fill_valid_i = 1'b1; fill_big_i = 1'b0; fill_vpn_i = 20'h55555;
    fill_pfn_i = 20'h66666; fill_attr_i = 4'b1111; flush_i = 1'b1;
    @(negedge clk); fill_valid_i = 1'b0; flush_i = 1'b0;
    look(32'h5555_5000, 1'b0);
    chk("R11 fill with flush dropped", {31'b0, rsp_hit_o}, 32'd0);
    fill_valid_i = 1'b1; fill_vpn_i = 20'h57575; inval_vpn_i = 20'h99999; inval_i = 1'b1;
    @(negedge clk); fill_valid_i = 1'b0; inval_i = 1'b0;
    look(32'h5757_5000, 1'b0);
    chk("R11 fill with inval dropped", {31'b0, rsp_hit_o}, 32'd0);

    // R9 / R10 round-robin replacement on a full set
    do_reset();
    for (int i = 0; i < 32; i++)
      fill(1'b0, (32'h100 + i) << 12, 20'h50000 + 20'(i), 4'b1110);
    fill(1'b0, 32'h0010_5000, 20'h6AAAA, 4'b1110);
    fill(1'b0, 32'h0020_0000, 20'h77777, 4'b1110);
    look(32'h0010_0000, 1'b0);
    chk("R9 oldest evicted", {31'b0, rsp_walk_o}, 32'd1);
    look(32'h0010_1008, 1'b0);
    chk("R9 second kept", rsp_paddr_o, 32'h5000_1008);
    look(32'h0020_0000, 1'b0);
    chk("R9 new entry", rsp_paddr_o, 32'h7777_7000);
    look(32'h0010_5000, 1'b0);
    chk("R10 in-place refill", rsp_paddr_o, 32'h6AAA_A000);
    look(32'h0011_F000, 1'b0);
    chk("R10 last entry kept", rsp_paddr_o, 32'h5001_F000);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule